// File: doc/BRIEF.md
# Two-Wire Slave Front End with Busy Polling

This block is the bus-facing half of a two-wire serial slave. It runs entirely in the system clock domain and treats SCL and SDA as slow, oversampled inputs. It brings both lines into the clock domain and finds start and stop conditions. It then collects an 8-bit address, made of a fixed device-type nibble followed by four strapped bits. When the address matches, the block acknowledges it and passes every later byte to a command executor as a one-cycle strobe. When the executor asks for read data, the block shifts out a byte by pulling the line low or releasing it. SDA is open-drain, so the block only ever pulls the line low or lets it go.

While the executor reports that a nonvolatile write is in progress, the block does not acknowledge its own address. A host can therefore poll for the end of the write by sending the address again until it is acknowledged. A wrong address, or a host that does not acknowledge read data, sends the block into a quiet state. It stays there until the next start condition. A start condition seen at any point throws away the current transfer and begins address collection again.

FSM states: `ST_IDLE` waits for a start. `ST_ADDR` collects the address. `ST_ADDR_ACK` drives the address acknowledge. `ST_RX` collects a byte. `ST_RX_ACK` drives the byte acknowledge. `ST_TX` shifts out a read byte. `ST_TX_ACK` samples the host's acknowledge. `ST_IGNORE` stays quiet until the next start.

Transitions:
- Any state goes to `ST_ADDR` on a start condition and to `ST_IDLE` on a stop condition.
- `ST_ADDR` goes to `ST_ADDR_ACK` (address matches and no write is busy) or to `ST_IGNORE` (mismatch or busy), at the SCL fall that follows the eighth bit.
- `ST_ADDR_ACK` and `ST_RX_ACK` go, when the acknowledge clock falls, to `ST_TX` if read data is requested and to `ST_RX` otherwise.
- `ST_RX` goes to `ST_RX_ACK` after eight bits.
- `ST_TX` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes to `ST_TX` (host acknowledged and more data requested), `ST_RX` (host acknowledged, no more data) or `ST_IGNORE` (host did not acknowledge).

Top module: `tw_poll_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high. A stop condition is SDA rising while SCL is high. A stop always returns the block to idle with the bus released.
- R2: Before the first start condition, clocked bits are neither acknowledged nor delivered.
- R3: The address is acknowledged only when its upper four bits are binary 0101 and its lower four bits equal `strap_addr` (bit 3 to bit 3). Bits arrive most significant first and are sampled on the rising edge of SCL.
- R4: After an address mismatch, the block drives no acknowledge and delivers no byte until the next start condition.
- R5: The block pulls SDA low (`sda_oe`=1) during the ninth clock after a matching address and after every received byte.
- R6: Each received byte appears on `rx_data` with a one-cycle `rx_valid` pulse. `rx_first` is 1 only for the first byte after the address.
- R7: While `nv_busy` is high at the end of the address byte, a matching address is not acknowledged and the block goes quiet until the next start condition.
- R8: A repeated start in the middle of a transfer, even in the middle of a byte, restarts address collection.
- R9: If `tx_req` is high when an acknowledge clock ends, the next byte is `tx_byte`, sent most significant first. Each byte loaded for sending gives one `tx_load` pulse. If the host does not acknowledge, the block goes quiet until the next start condition.
- R10: `sda_oe` changes only while SCL is low.
- R11: A stop that ends a transfer whose address was acknowledged gives one `xfer_stop` pulse. A stop in idle or in the quiet state gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_addr | input | 4 | Strapped low address bits |
| nv_busy | input | 1 | Nonvolatile write in progress |
| tx_req | input | 1 | Executor wants the next byte to be a read byte |
| tx_byte | input | 8 | Read data to send |
| tx_load | output | 1 | Pulse: `tx_byte` was taken |
| rx_valid | output | 1 | Pulse: `rx_data` holds a received byte |
| rx_data | output | 8 | Received byte |
| rx_first | output | 1 | Received byte is the first after the address |
| xfer_stop | output | 1 | Pulse: an acknowledged transfer ended with a stop |

## Verification
The bench builds the block with the default parameters: type code 0101, four strap bits and a two-stage synchronizer. It changes the strap pins between transfers, so more than one matching address is exercised. With a bit phase of six clocks and three clocks of synchronizer delay, every acknowledge turnaround falls well inside the SCL-low window. That spacing lets a per-clock monitor check the SCL-high stability of `sda_oe` and every `rx_valid` strobe against a queue of expected bytes.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] now,
    output logic [LINES-1:0] prev
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain   <= '1;
                prev[g] <= 1'b1;
            end else begin
                chain   <= {chain[STAGES-2:0], raw[g]};
                prev[g] <= chain[STAGES-1];
            end
        end
        assign now[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [W-1:0]  ld_val,
    input  logic          take,
    input  logic          bit_in,
    input  logic          tick,
    input  logic          shl,
    output logic [W-1:0]  q,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            cnt <= '0;
        end else if (clr) begin
            q   <= '0;
            cnt <= '0;
        end else if (load) begin
            q   <= ld_val;
            cnt <= '0;
        end else if (take) begin
            q   <= {q[W-2:0], bit_in};
            cnt <= cnt + 1'b1;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end else if (shl) begin
            q   <= {q[W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/tw_poll_slave.sv
module tw_poll_slave
    import tw_pkg::*;
#(
    parameter int              TYPE_W      = 4,
    parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b0101,
    parameter int              STRAP_W     = 4,
    parameter int              SYNC_STAGES = 2,
    localparam int             BYTE_W      = TYPE_W + STRAP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               nv_busy,
    input  logic               tx_req,
    input  logic [BYTE_W-1:0]  tx_byte,
    output logic               tx_load,
    output logic               rx_valid,
    output logic [BYTE_W-1:0]  rx_data,
    output logic               rx_first,
    output logic               xfer_stop
);
    localparam int CW = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTE_W);

    logic [1:0] ln_now, ln_prev;
    logic scl_s, sda_s, scl_p, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;

    tw_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}),
        .now(ln_now), .prev(ln_prev)
    );
    assign {scl_s, sda_s} = ln_now;
    assign {scl_p, sda_p} = ln_prev;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    tw_state_e state_q, state_d;
    logic first_q, first_d, mack_q, mack_d;
    logic sh_clr, sh_load, sh_take, sh_tick, sh_shl;
    logic rx_pulse, stop_pulse, load_pulse;
    logic [BYTE_W-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic addr_hit;

    tw_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(sh_load), .ld_val(tx_byte),
        .take(sh_take), .bit_in(sda_s), .tick(sh_tick), .shl(sh_shl),
        .q(sh_q), .cnt(cnt_q)
    );

    assign addr_hit = (sh_q == {TYPE_CODE, strap_addr});

    // next-state and datapath control
    always_comb begin
        state_d    = state_q;
        first_d    = first_q;
        mack_d     = mack_q;
        sh_clr     = 1'b0;
        sh_load    = 1'b0;
        sh_take    = 1'b0;
        sh_tick    = 1'b0;
        sh_shl     = 1'b0;
        rx_pulse   = 1'b0;
        stop_pulse = 1'b0;
        load_pulse = 1'b0;
        if (stop_det) begin
            state_d    = ST_IDLE;
            stop_pulse = (state_q != ST_IDLE) && (state_q != ST_IGNORE) && (state_q != ST_ADDR);
        end else if (start_det) begin
            state_d = ST_ADDR;
            sh_clr  = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR: begin
                    if (scl_rise && cnt_q != FULL) sh_take = 1'b1;
                    else if (scl_fall && cnt_q == FULL) begin
                        if (addr_hit && !nv_busy) begin
                            state_d = ST_ADDR_ACK;
                            first_d = 1'b1;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK, ST_RX_ACK: begin
                    if (scl_fall) begin
                        if (tx_req) begin
                            state_d    = ST_TX;
                            sh_load    = 1'b1;
                            load_pulse = 1'b1;
                        end else begin
                            state_d = ST_RX;
                            sh_clr  = 1'b1;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise && cnt_q != FULL) sh_take = 1'b1;
                    else if (scl_fall && cnt_q == FULL) begin
                        state_d  = ST_RX_ACK;
                        rx_pulse = 1'b1;
                        first_d  = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) sh_tick = 1'b1;
                    else if (scl_fall) begin
                        if (cnt_q == FULL) state_d = ST_TX_ACK;
                        else sh_shl = 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) mack_d = ~sda_s;
                    else if (scl_fall) begin
                        if (mack_q && tx_req) begin
                            state_d    = ST_TX;
                            sh_load    = 1'b1;
                            load_pulse = 1'b1;
                        end else if (mack_q) begin
                            state_d = ST_RX;
                            sh_clr  = 1'b1;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            first_q <= first_d;
            mack_q  <= mack_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            rx_first  <= 1'b0;
            xfer_stop <= 1'b0;
            tx_load   <= 1'b0;
        end else begin
            rx_valid  <= rx_pulse;
            xfer_stop <= stop_pulse;
            tx_load   <= load_pulse;
            if (rx_pulse) begin
                rx_data  <= sh_q;
                rx_first <= first_q;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_RX_ACK: sda_oe = 1'b1;
            ST_TX:                  sda_oe = ~sh_q[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

    // assertions
    p_oe_quiet_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && scl_p) |-> $stable(sda_oe));
    p_busy_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && scl_fall && cnt_q == FULL && nv_busy) |=> (state_q == ST_IGNORE));
    p_start_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state_q == ST_ADDR && cnt_q == '0));
    p_rx_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    p_ignore_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && !start_det) |=> (!sda_oe && !rx_valid));
    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_oe));
endmodule

// File: tb/test_tw_poll_slave.sv
module test_tw_poll_slave;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_bus;
    logic [3:0] strap = 4'b1010;
    logic nv_busy = 1'b0, tx_req = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic tx_load, rx_valid, rx_first, xfer_stop;
    logic [7:0] rx_data;

    int n_tests = 0, n_fail = 0;
    int stops = 0, loads = 0;
    int exp_q[$];
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    tw_poll_slave i_tw_poll_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_addr(strap), .nv_busy(nv_busy), .tx_req(tx_req), .tx_byte(tx_byte),
        .tx_load(tx_load), .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
        .xfer_stop(xfer_stop)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock reference monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_scl && scl_m && sda_oe != prev_oe)
                check(1'b0, "R10 oe moved with SCL high", int'(sda_oe), int'(prev_oe));
            if (rx_valid) begin
                if (exp_q.size() == 0) check(1'b0, "R6/R4 unexpected byte", int'(rx_data), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check({rx_first, rx_data} == 9'(e), "R6 rx byte", int'({rx_first, rx_data}), e);
                end
            end
            if (xfer_stop) stops++;
            if (tx_load) loads++;
        end
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic clk_bit(input bit b, output bit seen);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(Q);
        @(negedge clk) seen = sda_bus;
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic read_byte(input bit host_ack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(!host_ack, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] rd;
        wq(4); rst_n = 1'b1; wq(2);
        @(negedge clk);
        check(sda_oe == 1'b0, "R1 reset releases bus", int'(sda_oe), 0);
        check(rx_valid == 1'b0, "R6 reset no strobe", int'(rx_valid), 0);

        // R2: bits with no start
        scl_m = 1'b0; wq(Q);
        send_byte(8'h5A, a);
        check(!a, "R2 no ack before start", int'(a), 0);
        send_byte(8'h11, a);
        check(!a, "R2 no byte before start", int'(a), 0);
        bus_stop();

        // R3 R5 R6 R11: write transfer
        bus_start();
        send_byte(8'h5A, a);
        check(a, "R3 address ack", int'(a), 1);
        exp_q.push_back(9'h19C);
        send_byte(8'h9C, a);
        check(a, "R5 command ack", int'(a), 1);
        exp_q.push_back(9'h03F);
        send_byte(8'h3F, a);
        check(a, "R5 data ack", int'(a), 1);
        bus_stop(); wq(4);
        check(stops == 1, "R11 stop pulse", stops, 1);

        // R4: wrong type nibble
        bus_start();
        send_byte(8'h7A, a);
        check(!a, "R4 type mismatch nack", int'(a), 0);
        send_byte(8'h5A, a);
        check(!a, "R4 ignored until start", int'(a), 0);
        bus_stop(); wq(4);
        check(stops == 1, "R11 no stop pulse when ignored", stops, 1);

        // R3 R4: strap compare
        bus_start();
        send_byte(8'h5B, a);
        check(!a, "R4 strap mismatch nack", int'(a), 0);
        bus_stop();
        strap = 4'b0011;
        bus_start();
        send_byte(8'h53, a);
        check(a, "R3 new strap ack", int'(a), 1);
        bus_stop(); wq(4);
        check(stops == 2, "R11 stop after address only", stops, 2);
        strap = 4'b1010;

        // R7: busy polling
        nv_busy = 1'b1;
        bus_start();
        send_byte(8'h5A, a);
        check(!a, "R7 busy withholds ack", int'(a), 0);
        send_byte(8'h44, a);
        check(!a, "R7 quiet after busy nack", int'(a), 0);
        bus_stop();
        nv_busy = 1'b0;
        bus_start();
        send_byte(8'h5A, a);
        check(a, "R7 ack once idle", int'(a), 1);
        exp_q.push_back(9'h111);
        send_byte(8'h11, a);
        bus_stop(); wq(4);
        check(stops == 3, "R11 stop after poll", stops, 3);

        // R8: repeated start mid-byte
        bus_start();
        send_byte(8'h5A, a);
        begin
            bit s;
            clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
        end
        bus_start();
        send_byte(8'h5A, a);
        check(a, "R8 repeated start readdress", int'(a), 1);
        exp_q.push_back(9'h122);
        send_byte(8'h22, a);
        check(a, "R8 first byte after restart", int'(a), 1);
        bus_stop(); wq(4);
        check(stops == 4, "R1 stop ends transfer", stops, 4);

        // R9: read two bytes, host nacks the second
        bus_start();
        send_byte(8'h5A, a);
        tx_req  = 1'b1;
        tx_byte = 8'hA5;
        exp_q.push_back(9'h180);
        send_byte(8'h80, a);
        check(a, "R9 read command ack", int'(a), 1);
        read_byte(1'b1, rd);
        check(rd == 8'hA5, "R9 first read byte", int'(rd), 'hA5);
        read_byte(1'b0, rd);
        check(rd == 8'hA5, "R9 second read byte", int'(rd), 'hA5);
        tx_req = 1'b0;
        check(loads == 2, "R9 tx_load count", loads, 2);
        send_byte(8'h00, a);
        check(!a, "R9 quiet after host nack", int'(a), 0);
        bus_stop(); wq(4);
        check(stops == 4, "R11 no pulse after nack", stops, 4);

        wq(20);
        check(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule